// File: doc/BRIEF.md
# Display Window Update Sequencer

This block refreshes a rectangular region of a display controller's frame memory over a byte-wide command interface. A host presents a clip rectangle (`x1`, `x2`, `y1`, `y2`; both end coordinates are exclusive) and pulses `start`. The block then sends a column-range command, a row-range command and a memory-write command. After these it forwards the pixel bytes it pulls from a pixel source port, two bytes per 16-bit pixel. Every outgoing byte uses a valid/ready handshake and carries a D/C flag: 0 marks a command byte and 1 marks a parameter or pixel byte.

After reset, the block holds the panel's reset line low for a fixed number of milliseconds. It then releases the line and waits a further settling time before it accepts any work. The millisecond is a parameterised number of clock cycles. A separate status path checks a power-mode byte read back from the panel and reports whether the display is fully on. A blanking request writes zeros over the whole screen window without touching the pixel source. This is the path used when the panel is switched off and no backlight control exists.

Top module: `dwin_seq`

## Requirements
- R1: After reset, `panel_rst_n` is low for exactly RST_LOW_MS*CYC_PER_MS cycles following reset release and then goes high.
- R2: `init_done` rises RST_WAIT_MS*CYC_PER_MS cycles after `panel_rst_n` goes high. Before that, `busy` is 1, `out_valid` is 0, `disp_on` is 0 and `start` is ignored.
- R3: A transfer begins with command 0x2A (D/C 0) followed by four bytes with D/C 1: `x1[15:8]`, `x1[7:0]`, `x2[15:8]`, `(x2-1)[7:0]`. The high end byte comes from `x2`, not from `x2-1`.
- R4: Next comes command 0x2B (D/C 0) with the same four-byte layout built from `y1` and `y2`.
- R5: Next comes command 0x2C (D/C 0), then exactly (x2-x1)*(y2-y1)*2 bytes with D/C 1, taken in order from the pixel source. When this count is zero, the transfer ends after 0x2C.
- R6: `busy` goes high in the cycle after an accepted `start`. It stays high until the handshake of the final byte and is low in the cycle after that handshake.
- R7: A `start` or `blank_req` that arrives while `busy` is high is ignored. The stream in flight is unchanged and no further bytes follow it.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_dc` hold their values. A pixel byte is consumed only when it can be loaded into the output register.
- R9: When `pm_valid` is high, `disp_on` takes the value 1 exactly when `pm_byte` with bits 0, 1 and 7 cleared equals 0x1C. Otherwise `disp_on` holds its value.
- R10: `blank_req` sends the window 0..SCREEN_W by 0..SCREEN_H with the same R3-R5 framing, using zero bytes as pixel data. `pix_ready` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a window update with the current clip |
| blank_req | input | 1 | Begin a full-screen zero fill |
| x1 | input | CW | First column (inclusive) |
| x2 | input | CW | Column end (exclusive) |
| y1 | input | CW | First row (inclusive) |
| y2 | input | CW | Row end (exclusive) |
| pix_data | input | 8 | Pixel source byte |
| pix_valid | input | 1 | Pixel source byte available |
| pix_ready | output | 1 | Pixel byte taken this cycle |
| out_data | output | 8 | Outgoing command/parameter byte |
| out_dc | output | 1 | 0 = command, 1 = parameter or pixel |
| out_valid | output | 1 | Outgoing byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | Initialising or transfer in progress |
| init_done | output | 1 | Panel reset sequence finished |
| panel_rst_n | output | 1 | Active-low panel reset line |
| pm_byte | input | 8 | Power-mode status byte |
| pm_valid | input | 1 | Status byte present |
| disp_on | output | 1 | Last status byte showed the display fully on |

## Verification
The sequencer is run on a small screen and a short millisecond setting. It receives windows at the origin, windows at an offset, windows whose end crosses a 256 boundary, and windows of zero width. The crossing windows separate the high-byte-from-`x2` rule from a plain `x2-1` encoding. The zero-width window shows that the stream stops right after the write command. Downstream ready and source valid are driven always on, in gapped patterns and alternating, which exposes lost, repeated or reordered bytes. All 256 power-mode values are swept, which shows that only the reserved bits are ignored.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
  localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
  localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
  localparam int         HDR_LEN       = 11;
  localparam logic [7:0] PM_KEEP_MASK  = 8'h7C;
  localparam logic [7:0] PM_ON_VALUE   = 8'h1C;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_READY = 2'd2
  } boot_ph_t;
endpackage

// File: rtl/dwin_rst_timer.sv
module dwin_rst_timer
  import dwin_pkg::*;
#(
  parameter int CYC_PER_MS  = 50000,
  parameter int RST_LOW_MS  = 20,
  parameter int RST_WAIT_MS = 120
) (
  input  logic clk,
  input  logic rst,
  output logic panel_rst_n,
  output logic init_done
);
  localparam int LOW_CYC  = CYC_PER_MS * RST_LOW_MS;
  localparam int WAIT_CYC = CYC_PER_MS * RST_WAIT_MS;
  localparam int MAX_CYC  = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  boot_ph_t        ph;
  logic [TW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_HOLD;
      cnt         <= '0;
      panel_rst_n <= 1'b0;
      init_done   <= 1'b0;
    end else begin
      case (ph)
        PH_HOLD: begin
          if (cnt == TW'(LOW_CYC - 1)) begin
            ph          <= PH_SETTLE;
            cnt         <= '0;
            panel_rst_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt == TW'(WAIT_CYC - 1)) begin
            ph        <= PH_READY;
            init_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  rst_order_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> panel_rst_n);

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
endmodule

// File: rtl/dwin_pm_check.sv
module dwin_pm_check
  import dwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pm_byte,
  input  logic       pm_valid,
  output logic       disp_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on <= 1'b0;
    end else if (pm_valid) begin
      disp_on <= ((pm_byte & PM_KEEP_MASK) == PM_ON_VALUE);
    end
  end

  // R9
  pm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pm_valid |=> $stable(disp_on));
endmodule

// File: rtl/dwin_hdr_mux.sv
module dwin_hdr_mux
  import dwin_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [3:0]    idx,
  input  logic [CW-1:0] x1,
  input  logic [CW-1:0] x2,
  input  logic [CW-1:0] y1,
  input  logic [CW-1:0] y2,
  output logic [7:0]    hdr_byte,
  output logic          hdr_dc
);
  localparam int EW = (CW > 16) ? CW : 16;

  logic          row_part;
  logic [3:0]    slot;
  logic [EW-1:0] lo_c, hi_c, hi_m1;
  logic [7:0]    cmd;

  always_comb begin
    row_part = (idx >= 4'd5);
    slot     = row_part ? (idx - 4'd5) : idx;
    lo_c     = row_part ? EW'(y1) : EW'(x1);
    hi_c     = row_part ? EW'(y2) : EW'(x2);
    hi_m1    = hi_c - 1'b1;
    cmd      = (idx == 4'd10) ? CMD_MEM_WRITE :
               (row_part ? CMD_ROW_RANGE : CMD_COL_RANGE);
    hdr_dc   = 1'b1;
    case (slot)
      4'd1:    hdr_byte = lo_c[15:8];
      4'd2:    hdr_byte = lo_c[7:0];
      4'd3:    hdr_byte = hi_c[15:8];
      4'd4:    hdr_byte = hi_m1[7:0];
      default: begin
        hdr_byte = cmd;
        hdr_dc   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dwin_seq.sv
module dwin_seq
  import dwin_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SCREEN_W    = 240,
  parameter int SCREEN_H    = 320,
  parameter int CYC_PER_MS  = 50000,
  parameter int RST_LOW_MS  = 20,
  parameter int RST_WAIT_MS = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          blank_req,
  input  logic [CW-1:0] x1,
  input  logic [CW-1:0] x2,
  input  logic [CW-1:0] y1,
  input  logic [CW-1:0] y2,
  input  logic [7:0]    pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic [7:0]    out_data,
  output logic          out_dc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          busy,
  output logic          init_done,
  output logic          panel_rst_n,
  input  logic [7:0]    pm_byte,
  input  logic          pm_valid,
  output logic          disp_on
);
  localparam int CNTW = 2 * CW + 5;

  logic            active, blank_mode;
  logic [CW-1:0]   cx1, cx2, cy1, cy2;
  logic [CNTW-1:0] gen, total, left;

  logic [CW-1:0]   wx1, wx2, wy1, wy2;
  logic [CW-1:0]   dx, dy;
  logic [CNTW-1:0] n_win;
  logic            in_hdr, room, can_load, launch;
  logic [7:0]      hdr_byte;
  logic            hdr_dc;

  dwin_rst_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .RST_LOW_MS (RST_LOW_MS),
    .RST_WAIT_MS(RST_WAIT_MS)
  ) u_boot (
    .clk        (clk),
    .rst        (rst),
    .panel_rst_n(panel_rst_n),
    .init_done  (init_done)
  );

  dwin_pm_check u_pm (
    .clk     (clk),
    .rst     (rst),
    .pm_byte (pm_byte),
    .pm_valid(pm_valid),
    .disp_on (disp_on)
  );

  dwin_hdr_mux #(.CW(CW)) u_hdr (
    .idx     (gen[3:0]),
    .x1      (cx1),
    .x2      (cx2),
    .y1      (cy1),
    .y2      (cy2),
    .hdr_byte(hdr_byte),
    .hdr_dc  (hdr_dc)
  );

  // Window chosen at launch: host clip or full screen.
  always_comb begin
    wx1   = start ? x1 : '0;
    wx2   = start ? x2 : CW'(SCREEN_W);
    wy1   = start ? y1 : '0;
    wy2   = start ? y2 : CW'(SCREEN_H);
    dx    = wx2 - wx1;
    dy    = wy2 - wy1;
    n_win = (CNTW'(dx) * CNTW'(dy)) << 1;
  end

  assign launch    = !active && init_done && (start || blank_req);
  assign in_hdr    = (gen < CNTW'(HDR_LEN));
  assign room      = !out_valid || out_ready;
  assign can_load  = active && (gen != total) && room &&
                     (in_hdr || blank_mode || pix_valid);
  assign pix_ready = active && !in_hdr && !blank_mode && (gen != total) && room;
  assign busy      = active || !init_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      blank_mode <= 1'b0;
      gen        <= '0;
      total      <= '0;
      left       <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_dc     <= 1'b0;
      cx1        <= '0;
      cx2        <= '0;
      cy1        <= '0;
      cy2        <= '0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        left      <= left - 1'b1;
        if (left == CNTW'(1)) active <= 1'b0;
      end
      if (can_load) begin
        out_valid <= 1'b1;
        out_data  <= in_hdr ? hdr_byte : (blank_mode ? 8'h00 : pix_data);
        out_dc    <= in_hdr ? hdr_dc : 1'b1;
        gen       <= gen + 1'b1;
      end
      if (launch) begin
        active     <= 1'b1;
        blank_mode <= !start;
        gen        <= '0;
        total      <= CNTW'(HDR_LEN) + n_win;
        left       <= CNTW'(HDR_LEN) + n_win;
        cx1        <= wx1;
        cx2        <= wx2;
        cy1        <= wy1;
        cy2        <= wy2;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dc));

  // R2
  quiet_init_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !out_valid && busy);

  // R3
  first_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |=> out_valid && (out_data == CMD_COL_RANGE) && !out_dc);

  // R10
  blank_src_chk: assert property (@(posedge clk) disable iff (rst)
    active && blank_mode |-> !pix_ready);

  // R6
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> busy);
endmodule

// File: tb/dwin_seq_tb.sv
module dwin_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 16;
  localparam int SW  = 4;
  localparam int SH  = 3;
  localparam int CPM = 4;
  localparam int LMS = 20;
  localparam int WMS = 120;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, blank_req = 1'b0;
  logic [CW-1:0] x1 = '0, x2 = '0, y1 = '0, y2 = '0;
  logic [7:0]    pix_data = '0;
  logic          pix_valid = 1'b0;
  logic          pix_ready;
  logic [7:0]    out_data;
  logic          out_dc, out_valid;
  logic          out_ready = 1'b0;
  logic          busy, init_done, panel_rst_n;
  logic [7:0]    pm_byte = '0;
  logic          pm_valid = 1'b0;
  logic          disp_on;

  dwin_seq #(
    .CW(CW), .SCREEN_W(SW), .SCREEN_H(SH),
    .CYC_PER_MS(CPM), .RST_LOW_MS(LMS), .RST_WAIT_MS(WMS)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .blank_req(blank_req),
    .x1(x1), .x2(x2), .y1(y1), .y2(y2),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .out_data(out_data), .out_dc(out_dc), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .init_done(init_done),
    .panel_rst_n(panel_rst_n), .pm_byte(pm_byte), .pm_valid(pm_valid),
    .disp_on(disp_on)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rmode = 0;
  int vmode = 0;
  int cap_n = 0;
  int pix_idx = 0;
  int pix_base = 0;
  logic [8:0] cap [0:63];
  logic [8:0] expv [0:63];
  int exp_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  // Sink and pixel source, both driven and sampled between edges.
  always begin
    @(negedge clk);
    cyc++;
    case (rmode)
      1:       out_ready = (cyc % 3) != 0;
      2:       out_ready = (cyc % 2) == 0;
      default: out_ready = 1'b1;
    endcase
    pix_valid = (vmode == 0) ? 1'b1 : ((cyc % 4) != 1);
    pix_data  = 8'((pix_base + pix_idx) & 255);
    #1;
    if (out_valid && out_ready) begin
      if (cap_n < 64) cap[cap_n] = {out_dc, out_data};
      cap_n++;
    end
    if (pix_valid && pix_ready) pix_idx++;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push(input bit dc, input int b);
    expv[exp_n] = {dc, 8'(b & 255)};
    exp_n++;
  endtask

  task automatic run_win(input int a1, input int a2, input int b1, input int b2,
                         input bit blank, input int rm, input int vm, input bit poke,
                         input string tag);
    int n;
    int guard;
    bit prev_full;
    bit ok;
    rmode = rm;
    vmode = vm;
    @(negedge clk);
    #2;
    cap_n    = 0;
    pix_idx  = 0;
    pix_base = a1 * 7 + b1 + 3;
    exp_n    = 0;
    push(0, 8'h2A); push(1, a1 >> 8); push(1, a1); push(1, a2 >> 8); push(1, a2 - 1);
    push(0, 8'h2B); push(1, b1 >> 8); push(1, b1); push(1, b2 >> 8); push(1, b2 - 1);
    push(0, 8'h2C);
    n = (a2 - a1) * (b2 - b1) * 2;
    for (int k = 0; k < n; k++) push(1, blank ? 0 : (pix_base + k));
    x1 = CW'(a1); x2 = CW'(a2); y1 = CW'(b1); y2 = CW'(b2);
    if (blank) blank_req = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blank_req = 1'b0;
    #2;
    chk(busy == 1'b1, {"R6 busy after launch ", tag}, int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      x1 = CW'(0); x2 = CW'(9); y1 = CW'(0); y2 = CW'(9);
      start = 1'b1;
      blank_req = 1'b1;
      @(negedge clk);
      start = 1'b0;
      blank_req = 1'b0;
      #2;
    end
    guard = 0;
    prev_full = 0;
    while (busy && guard < 5000) begin
      if (prev_full) begin
        chk(1'b0, {"R6 busy late ", tag}, int'(busy), 0);
        guard = 5000;
      end
      prev_full = (cap_n == exp_n);
      @(negedge clk);
      #2;
      guard++;
    end
    chk(cap_n == exp_n, {"R5 R6 byte count at busy drop ", tag}, cap_n, exp_n);
    ok = 1;
    for (int k = 0; k < 11 && k < cap_n; k++)
      if (cap[k] !== expv[k]) begin
        ok = 0;
        $display("FAIL R3 R4 header byte %0d %s actual=%0h expected=%0h", k, tag, cap[k], expv[k]);
      end
    chk(ok, {"R3 R4 header ", tag}, 0, 0);
    ok = 1;
    for (int k = 11; k < exp_n && k < cap_n && k < 64; k++)
      if (cap[k] !== expv[k]) begin
        ok = 0;
        $display("FAIL R5 R8 pixel byte %0d %s actual=%0h expected=%0h", k, tag, cap[k], expv[k]);
      end
    chk(ok, {"R5 R8 pixel stream ", tag}, 0, 0);
    if (blank) chk(pix_idx == 0, {"R10 source untouched ", tag}, pix_idx, 0);
    else       chk(pix_idx == n, {"R5 source bytes taken ", tag}, pix_idx, n);
    if (poke) begin
      repeat (20) @(negedge clk);
      #2;
      chk(cap_n == exp_n && !busy, {"R7 no extra transfer ", tag}, cap_n, exp_n);
    end
  endtask

  initial begin
    int low_cnt;
    int wait_cnt;
    int g;
    bit e;
    repeat (3) @(negedge clk);
    #2;
    chk(panel_rst_n == 1'b0, "R1 reset line low in reset", int'(panel_rst_n), 0);
    chk(busy == 1'b1 && out_valid == 1'b0, "R2 reset busy/out_valid", int'({busy, out_valid}), 2);
    chk(disp_on == 1'b0 && init_done == 1'b0, "R2 reset disp_on/init_done", int'({disp_on, init_done}), 0);
    @(negedge clk);
    rst = 1'b0;
    low_cnt = 0;
    wait_cnt = 0;
    g = 0;
    #2;
    while (!init_done && g < 2000) begin
      if (!panel_rst_n) low_cnt++;
      else wait_cnt++;
      if (g == 300) start = 1'b1;
      else start = 1'b0;
      chk(!out_valid || g % 50 != 0, "R2 quiet during init", int'(out_valid), 0);
      @(negedge clk);
      #2;
      g++;
    end
    start = 1'b0;
    chk(low_cnt == LMS * CPM, "R1 reset low cycles", low_cnt, LMS * CPM);
    chk(wait_cnt == WMS * CPM, "R2 settle cycles", wait_cnt, WMS * CPM);
    repeat (5) @(negedge clk);
    #2;
    chk(cap_n == 0 && !busy, "R2 start during init ignored", cap_n, 0);

    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pm_byte = 8'(v);
      pm_valid = 1'b1;
      @(negedge clk);
      pm_valid = 1'b0;
      pm_byte = 8'(v ^ 8'h5A);
      #2;
      e = ((v & 8'h7C) == 8'h1C);
      chk(disp_on == e, $sformatf("R9 status value %0h", v), int'(disp_on), int'(e));
      if (v == 8'h9F || v == 8'h1C) begin
        @(negedge clk);
        #2;
        chk(disp_on == e, "R9 hold without valid", int'(disp_on), int'(e));
      end
    end

    run_win(0, 2, 0, 1, 0, 0, 0, 0, "origin");
    run_win(3, 5, 1, 3, 0, 1, 1, 0, "offset stalled");
    run_win(250, 256, 511, 512, 0, 2, 0, 0, "end crosses 256");
    run_win(5, 5, 0, 2, 0, 1, 0, 0, "zero width");
    run_win(1, 4, 2, 4, 0, 0, 1, 1, "launch while busy");
    run_win(0, SW, 0, SH, 1, 1, 0, 0, "blank");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule